// File: doc/BRIEF.md
# UART Receive FIFO with Line Status

This block buffers received characters for one UART channel and builds the 8-bit line status word that a host reads. The receiver presents each finished character as a one-cycle strobe together with its break, framing-error and parity-error flags. Every character is stored with its own flags in a 64-deep first-in first-out store. The flags shown in the status word are always those of the oldest stored character, which is the next one to be read.

The host has two read strobes. A status read returns the status word and clears a pending overrun. A data read takes the oldest character off the store. The host should read the status word before the data byte, so that it sees the byte's error flags. A separate summary bit shows whether any stored character carries an error. A counter of flagged entries keeps this bit correct, and it stays set until the last flagged character has been read. Two transmit-side empty indications are passed through into the status word.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: After reset the store is empty. lsr_o bits 0, 1, 2, 3, 4 and 7 read 0, and rhr_data_o reads 0x00.
- R2: The store holds DEPTH (64) characters. rx_valid_i stores a character on the clock edge, and rhr_rd_i removes the oldest one on the clock edge. Characters leave in arrival order. rhr_data_o always shows the oldest character. lsr_o[0] is 1 exactly when at least one character is stored.
- R3: lsr_o[4], lsr_o[3] and lsr_o[2] show the break, framing and parity flags of the oldest stored character. All three read 0 when the store is empty.
- R4: lsr_rd_i never removes a character or changes the stored contents.
- R5: A character stored with its break flag set always holds data 0x00, whatever value rx_data_i has.
- R6: lsr_o[7] is 1 exactly when at least one stored character has a break, framing or parity flag set. This stays true when a store and a removal happen in the same cycle.
- R7: If a character arrives while the store is full and no data read happens in that cycle, the character is dropped, the stored contents stay unchanged, and lsr_o[1] becomes 1 from the next cycle. If a data read happens in the same cycle, the new character is accepted.
- R8: lsr_o[1] returns to 0 in the cycle after a status read. If a new overrun happens in the same cycle as the status read, lsr_o[1] stays 1.
- R9: A data read while the store is empty shows 0x00 on rhr_data_o and changes no state.
- R10: lsr_o[5] follows thr_empty_i and lsr_o[6] follows tx_idle_i, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Strobe: a received character is ready |
| rx_data_i | input | 8 | Received character |
| rx_brk_i | input | 1 | Break detected for this character |
| rx_fe_i | input | 1 | Framing error for this character |
| rx_pe_i | input | 1 | Parity error for this character |
| lsr_rd_i | input | 1 | Host status read strobe |
| rhr_rd_i | input | 1 | Host data read strobe (removes one character) |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tx_idle_i | input | 1 | Holding register and shift register both empty |
| rhr_data_o | output | 8 | Oldest stored character, 0x00 when the store is empty |
| lsr_o | output | 8 | Line status word |

## Verification
The hardest case to reach is the overrun edge. The store must be completely full, and then an arrival must come either alone or together with a data read or a status read. The stimulus fills all 64 slots with a known pattern and then drives these combinations. After that it drains the whole store, so the pattern proves that dropped characters left no trace. A second difficult case is the error summary bit when a flagged arrival and a flagged removal happen in the same cycle. The stimulus builds that case on purpose and checks that the summary bit stays set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  rx_entry_t       wr_entry_i,
  input  logic            rd_i,
  output rx_entry_t       head_o,
  output logic [CW-1:0]   count_o,
  output logic            full_o,
  output logic            empty_o
);
  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q] <= wr_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_i) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  a_r7_no_write_into_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i |-> rd_i);
  a_r9_no_read_from_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !rd_i);
  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_flag_i,
  input  logic          pop_flag_i,
  input  logic [CW-1:0] fifo_count_i,
  output logic          any_err_o
);
  logic [CW-1:0] err_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_cnt_q <= '0;
    else case ({push_flag_i, pop_flag_i})
      2'b10:   err_cnt_q <= err_cnt_q + 1'b1;
      2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
      default: err_cnt_q <= err_cnt_q;
    endcase
  end

  assign any_err_o = (err_cnt_q != '0);

  a_r6_err_within_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q <= fifo_count_i);
  a_r6_push_pop_balance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_flag_i && pop_flag_i |=> $stable(err_cnt_q));
endmodule

// File: rtl/rx_lsr_gen.sv
module rx_lsr_gen
  import uart_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ovr_set_i,
  input  logic      lsr_rd_i,
  input  logic      empty_i,
  input  rx_entry_t head_i,
  input  logic      any_err_i,
  input  logic      thr_empty_i,
  input  logic      tx_idle_i,
  output logic [7:0] lsr_o
);
  logic ovr_q;

  // set has priority over the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= ovr_set_i | (ovr_q & ~lsr_rd_i);
  end

  logic [2:0] head_flags;
  assign head_flags = empty_i ? 3'b000 : {head_i.brk, head_i.fe, head_i.pe};

  assign lsr_o = {any_err_i, tx_idle_i, thr_empty_i, head_flags, ovr_q, ~empty_i};

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> ovr_q);
  a_r8_overrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !ovr_set_i |=> !ovr_q);
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_brk_i,
  input  logic       rx_fe_i,
  input  logic       rx_pe_i,
  input  logic       lsr_rd_i,
  input  logic       rhr_rd_i,
  input  logic       thr_empty_i,
  input  logic       tx_idle_i,
  output logic [7:0] rhr_data_o,
  output logic [7:0] lsr_o
);
  rx_entry_t     wr_entry, head;
  logic [CW-1:0] count;
  logic          full, empty, push, pop, ovr_set, any_err;

  assign pop     = rhr_rd_i & ~empty;
  assign push    = rx_valid_i & (~full | pop);
  assign ovr_set = rx_valid_i & full & ~pop;

  // break entries always carry a zero byte
  assign wr_entry.brk  = rx_brk_i;
  assign wr_entry.fe   = rx_fe_i;
  assign wr_entry.pe   = rx_pe_i;
  assign wr_entry.data = rx_brk_i ? 8'h00 : rx_data_i;

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_i(push), .wr_entry_i(wr_entry), .rd_i(pop),
    .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  rx_err_track #(.DEPTH(DEPTH)) u_err (
    .clk_i, .rst_ni,
    .push_flag_i(push & (rx_brk_i | rx_fe_i | rx_pe_i)),
    .pop_flag_i(pop & (head.brk | head.fe | head.pe)),
    .fifo_count_i(count),
    .any_err_o(any_err)
  );

  rx_lsr_gen u_lsr (
    .clk_i, .rst_ni,
    .ovr_set_i(ovr_set), .lsr_rd_i, .empty_i(empty), .head_i(head),
    .any_err_i(any_err), .thr_empty_i, .tx_idle_i, .lsr_o
  );

  assign rhr_data_o = empty ? 8'h00 : head.data;

  a_r4_status_read_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !rhr_rd_i && !rx_valid_i |=> $stable(count));
  a_r5_break_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && rx_brk_i |-> wr_entry.data == 8'h00);
endmodule

// File: tb/uart_rx_status_fifo_tb.sv
module uart_rx_status_fifo_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, brk = 0, fe = 0, pe = 0, lsr_rd = 0, rhr_rd = 0;
  logic thr_empty = 0, tx_idle = 0;
  logic [7:0] rx_data = 0, rhr_data, lsr;

  always #10 clk = ~clk;

  uart_rx_status_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_brk_i(brk), .rx_fe_i(fe), .rx_pe_i(pe), .lsr_rd_i(lsr_rd),
    .rhr_rd_i(rhr_rd), .thr_empty_i(thr_empty), .tx_idle_i(tx_idle),
    .rhr_data_o(rhr_data), .lsr_o(lsr)
  );

  int checks = 0, errors = 0;
  logic [10:0] q[$];  // {brk,fe,pe,data}
  logic ovr_m = 0;
  logic mon_en = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic any_flag();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  // driver: one cycle of stimulus, then update the scoreboard model
  task automatic cyc(input logic v, input logic [7:0] d, input logic b, input logic f,
                     input logic p, input logic lr, input logic rr);
    logic pop_m, acc_m;
    @(negedge clk);
    rx_valid = v; rx_data = d; brk = b; fe = f; pe = p; lsr_rd = lr; rhr_rd = rr;
    @(posedge clk);
    #1;
    pop_m = rr && q.size() > 0;
    acc_m = v && (q.size() < DEPTH || pop_m);
    ovr_m = (ovr_m && !lr) || (v && !acc_m);
    if (pop_m) void'(q.pop_front());
    if (acc_m) q.push_back({b, f, p, b ? 8'h00 : d});
    rx_valid = 0; lsr_rd = 0; rhr_rd = 0; brk = 0; fe = 0; pe = 0;
  endtask

  // monitor: compare outputs with the scoreboard head every cycle
  always @(negedge clk) if (mon_en) begin
    chk("R2 nonempty", lsr[0], q.size() > 0);
    chk("R2 head data", rhr_data, q.size() > 0 ? q[0][7:0] : 8'h00);
    chk("R3 head flags", lsr[4:2], q.size() > 0 ? q[0][10:8] : 3'b000);
    chk("R6 any error", lsr[7], any_flag());
    chk("R8 overrun", lsr[1], ovr_m);
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 lsr", lsr & 8'h9F, 8'h00);
    chk("R1 rhr", rhr_data, 8'h00);
    mon_en = 1;

    // R10 transmit pass-through
    thr_empty = 1; #1 chk("R10 thr", lsr[6:5], 2'b01);
    tx_idle = 1;   #1 chk("R10 idle", lsr[6:5], 2'b11);
    thr_empty = 0; #1 chk("R10 mix", lsr[6:5], 2'b10);

    // R2/R3 mixed flags
    cyc(1, 8'h41, 0, 0, 1, 0, 0);
    cyc(1, 8'h42, 0, 1, 0, 0, 0);
    cyc(1, 8'h43, 0, 0, 0, 0, 0);
    // R5 break forces zero data
    cyc(1, 8'h5A, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R5 stored entry", q[3][7:0], 8'h00);
    // R4 status reads do not pop
    repeat (3) cyc(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R4 size kept", q.size(), 4);
    chk("R4 head kept", rhr_data, 8'h41);
    repeat (4) cyc(0, 0, 0, 0, 0, 0, 1);

    // R9 read from empty
    cyc(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R9 empty data", rhr_data, 8'h00);
    chk("R9 empty flag", lsr[0], 1'b0);

    // R6 simultaneous flagged push and flagged pop
    cyc(1, 8'h11, 0, 0, 1, 0, 0);
    cyc(1, 8'h12, 0, 1, 0, 0, 1);
    @(negedge clk);
    chk("R6 simul", lsr[7], 1'b1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R6 cleared", lsr[7], 1'b0);

    // R7 fill to full
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 8'h80), 0, 0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk("R7 overrun set", lsr[1], 1'b1);
    chk("R7 size", q.size(), DEPTH);
    // R8 overrun and status read together: stays set
    cyc(1, 8'hEF, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R8 set wins", lsr[1], 1'b1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R8 cleared", lsr[1], 1'b0);
    // R7 full with simultaneous pop accepts
    cyc(1, 8'h77, 0, 1, 0, 0, 1);
    @(negedge clk);
    chk("R7 accept on pop", lsr[1], 1'b0);
    chk("R7 size kept", q.size(), DEPTH);
    while (q.size() > 0) cyc(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R2 drained", lsr[0], 1'b0);

    mon_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule